// File: doc/BRIEF.md
# Erased Sector Zero-Bit Screen

This block decides whether a flash sector that the error decoder could not repair is in fact a blank (erased) sector with a handful of bits stuck at zero. A blank sector reads as all ones in both its data and its check bytes. The check bytes of an all-ones payload are not valid codewords, so the decoder reports an uncorrectable failure. The surrounding logic starts this screen on that failure path. It then streams the sector's bytes through, one per cycle: data bytes first and check bytes after, with no gap needed between them.

Each accepted byte adds its number of zero bits to a running total. The total saturates at one above the correction limit: once it passes the limit, the outcome is already "not erased" and further counting would change nothing. The sector ends on the byte flagged as last, and that byte can be at any position. The block then raises a done level and reports whether the total stayed within the limit. When the sector is judged erased, the block also emits a burst of all-ones replacement bytes. The caller writes these over the data buffer, which removes the stray zeros.

Top module: `erased_sector_chk`

## Requirements
- R1: After reset, done_o, is_erased_o, fill_valid_o and fill_last_o are 0, zero_cnt_o is 0 and fill_byte_o is 0x00.
- R2: Each byte accepted during a sector adds the number of 0 bits in byte_i (the population count of its bitwise inverse) to zero_cnt_o, and the new total is visible on the cycle after the byte is accepted.
- R3: zero_cnt_o never exceeds LIMIT+1 (9 by default). Once the total passes LIMIT, it holds at LIMIT+1 until the next start_i.
- R4: start_i clears zero_cnt_o to 0 and done_o to 0 on the next cycle. Bytes presented while no sector is open (before the first start_i, or after done_o) are ignored, and zero_cnt_o and done_o are unchanged.
- R5: A cycle with byte_valid_i low adds nothing to the count, whatever byte_i carries.
- R6: done_o rises on the cycle after the accepted byte that has last_i high, and it stays high until the next start_i. While done_o is high, is_erased_o is 1 exactly when the total is at most LIMIT: a total of 8 is erased and a total of 9 is not.
- R7: When a sector is judged erased, fill_valid_o is high for FILL_BYTES consecutive cycles, starting on the cycle done_o rises. fill_byte_o is 0xFF on every one of those cycles, and fill_last_o is high on the final cycle only. A sector that is not erased produces no fill.
- R8: A sector may have any length from one byte up. The byte marked with last_i ends it, including a one-byte sector.
- R9: start_i received during a fill burst ends the burst, and fill_valid_o is low on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Opens a new sector and clears the count |
| byte_valid_i | input | 1 | byte_i carries a sector byte this cycle |
| byte_i | input | BYTE_W | Sector byte (data or check byte) |
| last_i | input | 1 | Marks the final byte of the sector |
| done_o | output | 1 | Sector finished; result valid |
| is_erased_o | output | 1 | Sector judged erased (valid with done_o) |
| zero_cnt_o | output | CNT_W | Saturated running zero-bit count |
| fill_valid_o | output | 1 | Replacement byte valid |
| fill_byte_o | output | BYTE_W | Replacement byte (all ones when valid) |
| fill_last_o | output | 1 | Final replacement byte |

## Verification
The hardest case to reach is the exact boundary of the limit: a sector of more than 500 bytes whose total is exactly 8 must pass, and one with exactly 9 must fail. Reaching it takes an all-ones sector with single zero-bearing bytes placed deep in the data and in the check bytes. The stimulus builds these sectors byte by byte, interleaves idle cycles that carry zero bytes with byte_valid_i low, and runs the full fill burst. Aborting a burst with start_i while it is running gets a directed sequence of its own.

// File: rtl/ezd_pkg.sv
package ezd_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SCAN = 2'd1,
    ST_DONE = 2'd2
  } ezd_state_e;
endpackage

// File: rtl/ezd_zero_count.sv
module ezd_zero_count #(
  parameter int BYTE_W = 8,
  localparam int ZW = $clog2(BYTE_W + 1)
) (
  input  logic [BYTE_W-1:0] byte_i,
  output logic [ZW-1:0]     zeros_o
);
  logic [BYTE_W-1:0] inv;
  assign inv = ~byte_i;

  always_comb begin
    zeros_o = '0;
    for (int k = 0; k < BYTE_W; k++) begin
      zeros_o = zeros_o + ZW'(inv[k]);
    end
  end
endmodule

// File: rtl/ezd_sat_accum.sv
module ezd_sat_accum #(
  parameter int BYTE_W = 8,
  parameter int LIMIT  = 8,
  localparam int ZW    = $clog2(BYTE_W + 1),
  localparam int CNT_W = $clog2(LIMIT + 2)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             add_en_i,
  input  logic [ZW-1:0]    add_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] cnt_nxt_o
);
  localparam int SW = $clog2(LIMIT + BYTE_W + 2);
  localparam logic [CNT_W-1:0] SAT = CNT_W'(LIMIT + 1);

  logic [CNT_W-1:0] cnt_q;
  logic [SW-1:0]    sum;

  assign sum = SW'(cnt_q) + SW'(add_i);

  // sum beyond limit collapses to SAT, so the register never wraps
  always_comb begin
    if (clr_i)              cnt_nxt_o = '0;
    else if (!add_en_i)     cnt_nxt_o = cnt_q;
    else if (sum > SW'(LIMIT)) cnt_nxt_o = SAT;
    else                    cnt_nxt_o = sum[CNT_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_nxt_o;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/ezd_ctrl.sv
module ezd_ctrl
  import ezd_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic byte_valid_i,
  input  logic last_i,
  output logic accept_o,
  output logic finish_o,
  output logic done_o
);
  ezd_state_e state_q, state_d;

  assign accept_o = (state_q == ST_SCAN) && byte_valid_i && !start_i;
  assign finish_o = accept_o && last_i;

  always_comb begin
    state_d = state_q;
    if (start_i)       state_d = ST_SCAN;
    else if (finish_o) state_d = ST_DONE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign done_o = (state_q == ST_DONE);
endmodule

// File: rtl/ezd_fill.sv
module ezd_fill #(
  parameter int BYTE_W     = 8,
  parameter int FILL_BYTES = 512,
  localparam int RW = $clog2(FILL_BYTES + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              launch_i,
  input  logic              abort_i,
  output logic              fill_valid_o,
  output logic [BYTE_W-1:0] fill_byte_o,
  output logic              fill_last_o
);
  logic [RW-1:0] rem_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           rem_q <= '0;
    else if (abort_i)      rem_q <= '0;
    else if (launch_i)     rem_q <= RW'(FILL_BYTES);
    else if (rem_q != '0)  rem_q <= rem_q - 1'b1;
  end

  assign fill_valid_o = (rem_q != '0);
  assign fill_last_o  = (rem_q == RW'(1));
  assign fill_byte_o  = fill_valid_o ? '1 : '0;
endmodule

// File: rtl/erased_sector_chk.sv
module erased_sector_chk #(
  parameter int BYTE_W     = 8,
  parameter int LIMIT      = 8,
  parameter int FILL_BYTES = 512,
  localparam int ZW    = $clog2(BYTE_W + 1),
  localparam int CNT_W = $clog2(LIMIT + 2)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              byte_valid_i,
  input  logic [BYTE_W-1:0] byte_i,
  input  logic              last_i,
  output logic              done_o,
  output logic              is_erased_o,
  output logic [CNT_W-1:0]  zero_cnt_o,
  output logic              fill_valid_o,
  output logic [BYTE_W-1:0] fill_byte_o,
  output logic              fill_last_o
);
  logic             accept, finish, launch;
  logic [ZW-1:0]    zeros;
  logic [CNT_W-1:0] cnt_nxt;

  ezd_ctrl u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (start_i),
    .byte_valid_i (byte_valid_i),
    .last_i       (last_i),
    .accept_o     (accept),
    .finish_o     (finish),
    .done_o       (done_o)
  );

  ezd_zero_count #(.BYTE_W(BYTE_W)) u_zc (
    .byte_i  (byte_i),
    .zeros_o (zeros)
  );

  ezd_sat_accum #(.BYTE_W(BYTE_W), .LIMIT(LIMIT)) u_acc (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (start_i),
    .add_en_i  (accept),
    .add_i     (zeros),
    .cnt_o     (zero_cnt_o),
    .cnt_nxt_o (cnt_nxt)
  );

  // fill launches on the same edge that raises done
  assign launch = finish && (cnt_nxt <= CNT_W'(LIMIT));

  ezd_fill #(.BYTE_W(BYTE_W), .FILL_BYTES(FILL_BYTES)) u_fill (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .launch_i     (launch),
    .abort_i      (start_i),
    .fill_valid_o (fill_valid_o),
    .fill_byte_o  (fill_byte_o),
    .fill_last_o  (fill_last_o)
  );

  assign is_erased_o = done_o && (zero_cnt_o <= CNT_W'(LIMIT));
endmodule

// File: rtl/ezd_chk.sv
module ezd_chk #(
  parameter int BYTE_W = 8,
  parameter int LIMIT  = 8,
  localparam int CNT_W = $clog2(LIMIT + 2)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic              byte_valid_i,
  input logic              done_i,
  input logic              is_erased_i,
  input logic [CNT_W-1:0]  zero_cnt_i,
  input logic              fill_valid_i,
  input logic [BYTE_W-1:0] fill_byte_i,
  input logic              fill_last_i
);
  // R3
  cnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    zero_cnt_i <= CNT_W'(LIMIT + 1));
  // R3
  sat_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (zero_cnt_i > CNT_W'(LIMIT) && !start_i) |=> zero_cnt_i == CNT_W'(LIMIT + 1));
  // R4
  start_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (!done_i && zero_cnt_i == '0));
  // R4
  idle_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && !start_i) |=> $stable(zero_cnt_i));
  // R5
  gap_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!byte_valid_i && !start_i) |=> $stable(zero_cnt_i));
  // R6
  done_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && !start_i) |=> done_i);
  // R7
  fill_ones_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_valid_i |-> fill_byte_i == '1);
  // R7
  fill_erased_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_valid_i |-> (done_i && is_erased_i));
  // R7
  fill_last_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_last_i |=> !fill_valid_i);
  // R9
  fill_abort_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> !fill_valid_i);
endmodule

bind erased_sector_chk ezd_chk #(.BYTE_W(BYTE_W), .LIMIT(LIMIT)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .start_i      (start_i),
  .byte_valid_i (byte_valid_i),
  .done_i       (done_o),
  .is_erased_i  (is_erased_o),
  .zero_cnt_i   (zero_cnt_o),
  .fill_valid_i (fill_valid_o),
  .fill_byte_i  (fill_byte_o),
  .fill_last_i  (fill_last_o)
);

// File: tb/erased_sector_chk_tb_top.sv
module erased_sector_chk_tb_top;
  localparam int LIM  = 8;
  localparam int FILL = 512;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0, valid = 1'b0, last = 1'b0;
  logic [7:0] byte_in = 8'h00;
  logic       done, erased, fvalid, flast;
  logic [3:0] cnt;
  logic [7:0] fbyte;

  int n_checks = 0, n_fail = 0;
  bit finished = 0;
  int fill_beats = 0, last_at = 0, bad_ff = 0;
  logic done_d = 1'b0;
  logic [4:0] exp_q[$];
  logic [7:0] sec_q[$];

  always #5 clk = ~clk;

  erased_sector_chk dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .byte_valid_i(valid),
    .byte_i(byte_in), .last_i(last), .done_o(done), .is_erased_o(erased),
    .zero_cnt_o(cnt), .fill_valid_o(fvalid), .fill_byte_o(fbyte), .fill_last_o(flast)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_zeros(input logic [7:0] b);
    int n = 0;
    for (int k = 0; k < 8; k++) if (!b[k]) n++;
    return n;
  endfunction

  // monitor: scoreboard on done rise, fill beat tracking
  always @(negedge clk) begin
    if (rst_n) begin
      if (done && !done_d) begin
        if (exp_q.size() == 0) check(0, "R6 unexpected done", 1, 0);
        else begin
          logic [4:0] e;
          e = exp_q.pop_front();
          check(erased == e[4], "R6 is_erased", int'(erased), int'(e[4]));
          check(cnt == e[3:0], "R2 final count", int'(cnt), int'(e[3:0]));
        end
      end
      if (fvalid) begin
        fill_beats++;
        if (fbyte != 8'hFF) bad_ff++;
        if (flast) last_at = fill_beats;
      end
      done_d <= done;
    end
  end

  task automatic make_sec(input int n, input logic [7:0] v);
    sec_q.delete();
    repeat (n) sec_q.push_back(v);
  endtask

  task automatic run_sector(input bit gaps);
    int acc = 0;
    foreach (sec_q[i]) begin
      acc += exp_zeros(sec_q[i]);
      if (acc > LIM) acc = LIM + 1;
    end
    exp_q.push_back({acc <= LIM, 4'(acc)});
    fill_beats = 0; last_at = 0; bad_ff = 0;
    start = 1'b1; @(negedge clk); start = 1'b0;
    for (int i = 0; i < sec_q.size(); i++) begin
      if (gaps && (i % 3 == 1)) begin
        valid = 1'b0; byte_in = 8'h00; last = 1'b1; @(negedge clk);
      end
      valid = 1'b1; byte_in = sec_q[i]; last = (i == sec_q.size() - 1);
      @(negedge clk);
    end
    valid = 1'b0; last = 1'b0; byte_in = 8'h00;
  endtask

  task automatic expect_fill(input bit er);
    repeat (FILL + 4) @(negedge clk);
    check(fill_beats == (er ? FILL : 0), "R7 fill length", fill_beats, er ? FILL : 0);
    check(bad_ff == 0, "R7 fill byte 0xFF", bad_ff, 0);
    if (er) check(last_at == FILL, "R7 fill_last position", last_at, FILL);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(!done && !erased && !fvalid && !flast, "R1 flags", {done, erased, fvalid, flast}, 0);
    check(cnt == 0 && fbyte == 8'h00, "R1 count/byte", int'(cnt), 0);

    // R8 full-length blank sector, R7 fill
    make_sec(525, 8'hFF);
    run_sector(0);
    expect_fill(1);

    // R6 boundary: exactly 8 zeros, deep in data and check bytes
    make_sec(525, 8'hFF);
    sec_q[300] = 8'hF0; sec_q[515] = 8'h0F;
    run_sector(0);
    expect_fill(1);

    // R3 boundary: 9 zeros -> not erased, no fill
    make_sec(525, 8'hFF);
    sec_q[10] = 8'h00; sec_q[524] = 8'hFE;
    run_sector(0);
    expect_fill(0);

    // R3 heavy zeros, saturation
    make_sec(40, 8'h00);
    run_sector(0);
    check(cnt == 4'(LIM + 1), "R3 saturated", int'(cnt), LIM + 1);
    expect_fill(0);

    // R4 bytes after done are ignored
    valid = 1'b1; byte_in = 8'h00; last = 1'b1;
    repeat (3) @(negedge clk);
    valid = 1'b0; last = 1'b0;
    check(cnt == 4'(LIM + 1), "R4 count unchanged after done", int'(cnt), LIM + 1);
    check(done == 1'b1, "R4 done held", int'(done), 1);
    check(fvalid == 1'b0, "R4 no fill from ignored bytes", int'(fvalid), 0);
    start = 1'b1; @(negedge clk); start = 1'b0;
    check(cnt == 0 && !done, "R4 start clears", int'(cnt), 0);

    // R2 running count, one cycle after acceptance
    exp_q.push_back({1'b1, 4'd5});
    fill_beats = 0; last_at = 0; bad_ff = 0;
    valid = 1'b1; byte_in = 8'hF0; @(negedge clk);
    check(cnt == 4, "R2 after 0xF0", int'(cnt), 4);
    byte_in = 8'hFE; @(negedge clk);
    check(cnt == 5, "R2 after 0xFE", int'(cnt), 5);
    byte_in = 8'hFF; last = 1'b1; @(negedge clk);
    valid = 1'b0; last = 1'b0;
    check(done == 1'b1, "R6 done after last", int'(done), 1);
    expect_fill(1);

    // R5 gap cycles carry zero bytes with valid low
    sec_q.delete();
    sec_q.push_back(8'hFF); sec_q.push_back(8'h7F); sec_q.push_back(8'hFF);
    sec_q.push_back(8'hBF); sec_q.push_back(8'hFF); sec_q.push_back(8'hFF);
    run_sector(1);
    check(cnt == 2, "R5 gaps ignored", int'(cnt), 2);
    expect_fill(1);

    // R8 single-byte sector
    make_sec(1, 8'h7E);
    run_sector(0);
    check(cnt == 2 && done, "R8 one-byte sector", int'(cnt), 2);
    expect_fill(1);

    // R9 abort fill with start
    make_sec(4, 8'hFF);
    run_sector(0);
    repeat (10) @(negedge clk);
    check(fvalid == 1'b1, "R7 fill running", int'(fvalid), 1);
    start = 1'b1; @(negedge clk); start = 1'b0;
    check(fvalid == 1'b0, "R9 fill aborted", int'(fvalid), 0);
    check(done == 1'b0, "R9 done cleared", int'(done), 0);
    repeat (3) @(negedge clk);
    check(fvalid == 1'b0, "R9 fill stays off", int'(fvalid), 0);

    check(exp_q.size() == 0, "R6 all results seen", exp_q.size(), 0);

    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end
endmodule